// File: doc/BRIEF.md
# Flash Write-Cycle Command Decoder

This block sits behind the host write port of a multi-bank NOR flash and turns a stream of host write cycles (word address plus data word) into single decoded command events. The commands are program, chip erase, sector erase, autoselect entry, autoselect exit, unlock-bypass entry, bypass program and bypass reset. Each event is a one-cycle pulse that carries the captured address, the data word and the bank number. An embedded-operation controller outside this block consumes the pulse. A cycle that does not fit the current step of a sequence drops the decoder back to the idle state of its current mode, and no command is issued.

Write cycles arrive on a valid/ready channel. The decoder never applies back-pressure: `wr_ready` is held high, and a cycle is consumed on every clock edge where `wr_valid` is high. The command output is a plain pulse without a ready signal, so the consumer must take it in the cycle it appears. The `mode` output tells the read path whether array reads, autoselect reads or bypass mode are in force.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, `mode` is 0 (array), `cmd_valid` is low and `wr_ready` is high.
- R2: The fixed cycles of a sequence compare only address bits 11..0 (555h or 2AAh) and data bits 7..0. Address bits 21..12 and data bits 15..8 have no effect on matching.
- R3: The cycles AAh@555h, 55h@2AAh, A0h@555h followed by any cycle (PA, PD) produce code 0 (program) with `cmd_addr`=PA and `cmd_data`=PD.
- R4: The cycles AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh followed by 10h@555h produce code 1 (chip erase). If the last cycle is instead 30h at any address SA, the result is code 2 (sector erase) with `cmd_addr`=SA.
- R5: The cycles AAh@555h, 55h@2AAh, 90h@555h produce code 3 and set `mode` to 1 (autoselect). In mode 1, 90h at any address followed by 00h produces code 4 and returns to mode 0. Any other single write in mode 1 leaves mode 1 unchanged.
- R6: The cycles AAh@555h, 55h@2AAh, 20h@555h produce code 5 and set `mode` to 2 (bypass). In mode 2, A0h followed by (PA, PD) produces code 6. In mode 2, 90h followed by 00h produces code 7 and returns to mode 0. Any other cycle in mode 2, F0h included, leaves the mode at 2.
- R7: In mode 0, a cycle whose address or data does not match the current step ends the sequence. The cycles that would have completed it produce no command.
- R8: Data F0h in any step of a mode-0 or mode-1 sequence returns the decoder to mode 0 idle without a command. The only exception is the program-data cycle, which takes F0h as ordinary data.
- R9: `cmd_valid` is high for exactly the one cycle after the write that completes a sequence. It is never high in two consecutive cycles.
- R10: `cmd_bank` holds address bits 21..20 of the completing write. For codes 4 and 7 it holds bits 21..20 of the preceding 90h write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write cycle present |
| wr_ready | output | 1 | Always high; a cycle is consumed whenever valid |
| wr_addr | input | 22 | Word address of the write cycle |
| wr_data | input | 16 | Data word of the write cycle |
| cmd_valid | output | 1 | One-cycle decoded command pulse |
| cmd_code | output | 3 | Command code 0..7 (see R3 to R6) |
| cmd_addr | output | 22 | Address of the completing write |
| cmd_data | output | 16 | Data of the completing write |
| cmd_bank | output | 2 | Bank the command targets |
| mode | output | 2 | 0 array, 1 autoselect, 2 bypass |

## Verification
The third unlock cycle is swept over all 256 data codes, with upper address bits that change from one code to the next. This separates the four codes that act from the codes that must fall back to idle. The erase sequence is replayed with a wrong address or wrong data at each of its six positions, which shows whether any step carries a partial match forward. A clean erase after each corrupted replay shows that the decoder recovered. Targeted patterns cover F0h at each kind of step, including as program data, autoselect and bypass exits with the bank taken from the 90h cycle, and unlock cycles carrying junk in the upper data byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [2:0] CMD_PROG       = 3'd0;
  localparam logic [2:0] CMD_CHIP_ERASE = 3'd1;
  localparam logic [2:0] CMD_SECT_ERASE = 3'd2;
  localparam logic [2:0] CMD_AS_ENTER   = 3'd3;
  localparam logic [2:0] CMD_AS_EXIT    = 3'd4;
  localparam logic [2:0] CMD_BYP_ENTER  = 3'd5;
  localparam logic [2:0] CMD_BYP_PROG   = 3'd6;
  localparam logic [2:0] CMD_BYP_RESET  = 3'd7;

  localparam logic [1:0] MODE_ARRAY   = 2'd0;
  localparam logic [1:0] MODE_AUTOSEL = 2'd1;
  localparam logic [1:0] MODE_BYPASS  = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PG,
    ST_E1, ST_E2, ST_E3,
    ST_AS, ST_AS_X,
    ST_BP, ST_BP_PG, ST_BP_X
  } seq_st_e;

  typedef struct packed {
    logic at_555;
    logic at_2aa;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_20;
    logic d_10;
    logic d_30;
    logic d_00;
    logic d_f0;
  } cyc_hit_t;

endpackage

// File: rtl/flash_cyc_match.sv
module flash_cyc_match
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic [CMP_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output cyc_hit_t          hit
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(12'h2AA);
  localparam int NCODE = 10;
  localparam logic [7:0] CODES [NCODE] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90,
                                            8'h20, 8'h10, 8'h30, 8'h00, 8'hF0};

  logic [7:0]       code_byte;
  logic [NCODE-1:0] dhit;

  assign code_byte = data[7:0];

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    assign dhit[i] = (code_byte == CODES[i]);
  end

  always_comb begin
    hit.at_555 = (addr_lo == ADR_A);
    hit.at_2aa = (addr_lo == ADR_B);
    hit.d_aa   = dhit[0];
    hit.d_55   = dhit[1];
    hit.d_a0   = dhit[2];
    hit.d_80   = dhit[3];
    hit.d_90   = dhit[4];
    hit.d_20   = dhit[5];
    hit.d_10   = dhit[6];
    hit.d_30   = dhit[7];
    hit.d_00   = dhit[8];
    hit.d_f0   = dhit[9];
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_valid,
  input  cyc_hit_t   hit,
  output logic       take,
  output logic       use_prev_bank,
  output logic       fire,
  output logic [2:0] fire_code,
  output logic [1:0] mode
);
  seq_st_e    st, st_n;
  logic [2:0] code_n;

  always_comb begin
    st_n          = st;
    take          = 1'b0;
    use_prev_bank = 1'b0;
    code_n        = CMD_PROG;
    if (cyc_valid) begin
      unique case (st)
        ST_IDLE: if (hit.at_555 && hit.d_aa) st_n = ST_U1;
        ST_U1:   st_n = (hit.at_2aa && hit.d_55) ? ST_U2 : ST_IDLE;
        ST_U2: begin
          st_n = ST_IDLE;
          if (hit.at_555) begin
            if (hit.d_a0)      st_n = ST_PG;
            else if (hit.d_80) st_n = ST_E1;
            else if (hit.d_90) begin
              st_n = ST_AS; take = 1'b1; code_n = CMD_AS_ENTER;
            end else if (hit.d_20) begin
              st_n = ST_BP; take = 1'b1; code_n = CMD_BYP_ENTER;
            end
          end
        end
        ST_PG: begin
          st_n = ST_IDLE; take = 1'b1; code_n = CMD_PROG;
        end
        ST_E1: st_n = (hit.at_555 && hit.d_aa) ? ST_E2 : ST_IDLE;
        ST_E2: st_n = (hit.at_2aa && hit.d_55) ? ST_E3 : ST_IDLE;
        ST_E3: begin
          st_n = ST_IDLE;
          if (hit.at_555 && hit.d_10) begin
            take = 1'b1; code_n = CMD_CHIP_ERASE;
          end else if (hit.d_30) begin
            take = 1'b1; code_n = CMD_SECT_ERASE;
          end
        end
        ST_AS: begin
          if (hit.d_90)      st_n = ST_AS_X;
          else if (hit.d_f0) st_n = ST_IDLE;
        end
        ST_AS_X: begin
          if (hit.d_00) begin
            st_n = ST_IDLE; take = 1'b1; use_prev_bank = 1'b1; code_n = CMD_AS_EXIT;
          end else if (hit.d_f0) st_n = ST_IDLE;
          else                   st_n = ST_AS;
        end
        ST_BP: begin
          if (hit.d_a0)      st_n = ST_BP_PG;
          else if (hit.d_90) st_n = ST_BP_X;
        end
        ST_BP_PG: begin
          st_n = ST_BP; take = 1'b1; code_n = CMD_BYP_PROG;
        end
        ST_BP_X: begin
          if (hit.d_00) begin
            st_n = ST_IDLE; take = 1'b1; use_prev_bank = 1'b1; code_n = CMD_BYP_RESET;
          end else st_n = ST_BP;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      fire      <= 1'b0;
      fire_code <= CMD_PROG;
    end else begin
      st   <= st_n;
      fire <= take;
      if (take) fire_code <= code_n;
    end
  end

  always_comb begin
    unique case (st)
      ST_AS, ST_AS_X:            mode = MODE_AUTOSEL;
      ST_BP, ST_BP_PG, ST_BP_X:  mode = MODE_BYPASS;
      default:                   mode = MODE_ARRAY;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [1:0]        mode
);
  localparam int BANK_LSB = ADDR_W - BANK_W;

  cyc_hit_t          hit;
  logic              take, use_prev_bank;
  logic [BANK_W-1:0] cur_bank, prev_bank;

  assign wr_ready = 1'b1;
  assign cur_bank = wr_addr[ADDR_W-1:BANK_LSB];

  flash_cyc_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
    .addr_lo (wr_addr[CMP_W-1:0]),
    .data    (wr_data),
    .hit     (hit)
  );

  flash_cmd_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_valid     (wr_valid),
    .hit           (hit),
    .take          (take),
    .use_prev_bank (use_prev_bank),
    .fire          (cmd_valid),
    .fire_code     (cmd_code),
    .mode          (mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_bank  <= '0;
      prev_bank <= '0;
    end else begin
      if (wr_valid) prev_bank <= cur_bank;
      if (take) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
        cmd_bank <= use_prev_bank ? prev_bank : cur_bank;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic [1:0] mode
);
  // R9: pulses never in consecutive cycles
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9: a pulse always follows an accepted write
  a_r9_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(wr_valid && wr_ready));

  // R1: leaving reset in array mode with no pulse
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == MODE_ARRAY && !cmd_valid));

  // R3: standard program only decoded from array mode
  a_r3_prog_from_array: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PROG) |-> $past(mode) == MODE_ARRAY);

  // R5: autoselect entry lands in autoselect mode
  a_r5_as_enter_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_AS_ENTER) |-> mode == MODE_AUTOSEL);

  // R6: bypass program only inside bypass mode, which it keeps
  a_r6_byp_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_BYP_PROG) |-> ($past(mode) == MODE_BYPASS && mode == MODE_BYPASS));

  // R6: bypass reset returns to array mode
  a_r6_byp_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_BYP_RESET) |-> ($past(mode) == MODE_BYPASS && mode == MODE_ARRAY));

  // R6: bypass mode is left only through a bypass reset pulse
  a_r6_bypass_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_BYPASS && mode != MODE_BYPASS) |-> (cmd_valid && cmd_code == CMD_BYP_RESET));
endmodule

bind flash_cmd_decoder flash_cmd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .mode      (mode)
);

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [21:0] cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  cmd_bank;
  logic [1:0]  mode;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_bank(cmd_bank), .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one write; on return the outputs show the effect of that write.
  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic none(input string req, input logic [1:0] m);
    chk(req, {31'd0, cmd_valid}, 32'd0);
    chk(req, {30'd0, mode}, {30'd0, m});
  endtask

  task automatic got(input string req, input logic [2:0] c, input logic [21:0] a,
                     input logic [15:0] d, input logic [1:0] b, input logic [1:0] m);
    chk(req, {31'd0, cmd_valid}, 32'd1);
    chk(req, {29'd0, cmd_code}, {29'd0, c});
    chk(req, {10'd0, cmd_addr}, {10'd0, a});
    chk(req, {16'd0, cmd_data}, {16'd0, d});
    chk(req, {30'd0, cmd_bank}, {30'd0, b});
    chk(req, {30'd0, mode}, {30'd0, m});
    @(negedge clk);
    chk("R9 pulse width", {31'd0, cmd_valid}, 32'd0);
  endtask

  task automatic unl(input logic [9:0] hi);
    wr({hi, 12'h555}, 16'h00AA); none("R2 unlock1", 2'd0);
    wr({hi, 12'h2AA}, 16'h0055); none("R2 unlock2", 2'd0);
  endtask

  task automatic chip_erase(input logic [9:0] hi, input string req);
    unl(hi);
    wr({hi, 12'h555}, 16'h0080); none(req, 2'd0);
    unl(hi);
    wr({hi, 12'h555}, 16'h0010);
    got(req, 3'd1, {hi, 12'h555}, 16'h0010, hi[9:8], 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [21:0] a [6];
    logic [15:0] d [6];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", {30'd0, mode}, 32'd0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R1 wr_ready", {31'd0, wr_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after release", {30'd0, mode}, 32'd0);

    // Sweep all third-cycle data codes
    for (int c = 0; c < 256; c++) begin
      logic [9:0]  hi;
      logic [21:0] pa;
      hi = 10'((c * 37) % 1024);
      pa = {hi, 12'((c * 91) % 4096)};
      unl(hi);
      wr({hi, 12'h555}, 16'(c) | 16'h3300);
      if (c == 8'h90) begin
        got("R5 as enter", 3'd3, {hi, 12'h555}, 16'h3390, hi[9:8], 2'd1);
        wr(22'h0, 16'h00F0); none("R8 F0 leaves autoselect", 2'd0);
      end else if (c == 8'h20) begin
        got("R6 bypass enter", 3'd5, {hi, 12'h555}, 16'h3320, hi[9:8], 2'd2);
        wr({~hi, 12'h123}, 16'h0090); none("R6 bypass x1", 2'd2);
        wr(22'h0, 16'h0000);
        got("R6 bypass reset", 3'd7, 22'h0, 16'h0000, ~hi[9:8], 2'd0);
      end else if (c == 8'hA0) begin
        none("R3 prog step", 2'd0);
        wr(pa, 16'(c * 257));
        got("R3 program", 3'd0, pa, 16'(c * 257), pa[21:20], 2'd0);
      end else begin
        none("R7 third-cycle code", 2'd0);
        wr(22'h0, 16'h00F0); none("R8 abort", 2'd0);
      end
    end

    // Corrupt each step of a chip erase
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 2; k++) begin
        a[0] = 22'h000555; d[0] = 16'h00AA;
        a[1] = 22'h0002AA; d[1] = 16'h0055;
        a[2] = 22'h000555; d[2] = 16'h0080;
        a[3] = 22'h000555; d[3] = 16'h00AA;
        a[4] = 22'h0002AA; d[4] = 16'h0055;
        a[5] = 22'h000555; d[5] = 16'h0010;
        if (k == 0 || p == 5) d[p] = d[p] ^ 16'h0001;
        else                  a[p] = a[p] ^ 22'h000001;
        for (int s = 0; s < 6; s++) begin
          wr(a[s], d[s]); none("R7 corrupted erase", 2'd0);
        end
        chip_erase(10'h0C0, "R4 chip erase after corrupt");
      end
    end

    // Sector erase, bank 3
    unl(10'h000);
    wr(22'h000555, 16'h0080); none("R4 step", 2'd0);
    unl(10'h3FF);
    wr(22'h3AB123, 16'h0030);
    got("R4 sector erase", 3'd2, 22'h3AB123, 16'h0030, 2'd3, 2'd0);

    // R2: junk in upper data byte and upper address bits
    wr(22'h2FF555, 16'h12AA); none("R2 hi data", 2'd0);
    wr(22'h1232AA, 16'hFF55); none("R2 hi data", 2'd0);
    wr(22'h3C5555, 16'h77A0); none("R2 hi data", 2'd0);
    wr(22'h10BEEF, 16'hCAFE);
    got("R2 program via junk", 3'd0, 22'h10BEEF, 16'hCAFE, 2'd1, 2'd0);

    // R8: F0 mid sequence, then remnants do nothing
    wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0055);
    wr(22'h000555, 16'h0080); wr(22'h000555, 16'h00AA);
    wr(22'h2AA000, 16'h00F0); none("R8 F0 mid erase", 2'd0);
    wr(22'h0002AA, 16'h0055); none("R8 remnant", 2'd0);
    wr(22'h000555, 16'h0010); none("R8 remnant", 2'd0);
    // R8: F0 as program data
    unl(10'h200);
    wr(22'h200555, 16'h00A0);
    wr(22'h201000, 16'h00F0);
    got("R8 F0 as program data", 3'd0, 22'h201000, 16'h00F0, 2'd2, 2'd0);

    // R5: autoselect exit and ignored writes
    unl(10'h100);
    wr(22'h100555, 16'h0090);
    got("R5 as enter", 3'd3, 22'h100555, 16'h0090, 2'd1, 2'd1);
    wr(22'h000555, 16'h00A0); none("R5 ignored in autoselect", 2'd1);
    wr(22'h000000, 16'h0090); none("R5 exit step", 2'd1);
    wr(22'h000000, 16'h0055); none("R5 broken exit stays", 2'd1);
    wr(22'h2C0000, 16'h0090); none("R5 exit step", 2'd1);
    wr(22'h000000, 16'h0000);
    got("R10 as exit bank from 90 cycle", 3'd4, 22'h000000, 16'h0000, 2'd2, 2'd0);

    // R6: bypass program, F0 ignored, broken reset stays
    unl(10'h000);
    wr(22'h000555, 16'h0020);
    got("R6 bypass enter", 3'd5, 22'h000555, 16'h0020, 2'd0, 2'd2);
    wr(22'h000000, 16'h00F0); none("R6 F0 ignored in bypass", 2'd2);
    wr(22'h000000, 16'h0090); wr(22'h000000, 16'h0011);
    none("R6 broken reset stays", 2'd2);
    for (int i = 0; i < 4; i++) begin
      wr(22'h3FFFFF, 16'h00A0); none("R6 bypass A0", 2'd2);
      wr(22'(i * 22'h100001), 16'(i + 16'h0A00));
      got("R6 bypass program", 3'd6, 22'(i * 22'h100001), 16'(i + 16'h0A00), 2'(i), 2'd2);
    end
    wr(22'h100000, 16'h0090); wr(22'h300000, 16'h0000);
    got("R10 bypass reset bank", 3'd7, 22'h300000, 16'h0000, 2'd1, 2'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule